// File: doc/BRIEF.md
# Sensor Bus Command Decoder

This block sits at the front of a sensor that answers as a slave on a two-wire sensor bus. An upstream deframer hands it one received message at a time as a single-cycle `msg_valid` pulse. Each message carries an 8-bit data field, a 4-bit address field, a 4-bit command code, a flag that tells a long frame from a short one, and a flag that says whether the frame check passed. The decoder drops every message that is damaged, uses an unsupported code, has the wrong frame length, or breaks a data-field rule. For each message it keeps, it raises a one-cycle strobe on the output bit whose index equals the command code.

The decoder also keeps the device's addressing state. After reset the device is uninitialized and listens only for an initialization message. That message must be a long frame sent to address zero, and its low data nibble gives the nonzero address to assign. Once the device holds an address, initialization is locked out until the next reset. From then on every other supported command is acted on only when its address field matches the assigned address.

Every accepted message schedules exactly one reply, to go out in the next bus transfer. The pending-reply flag and the code it answers hold until the next message arrives. At that point each message overwrites them, whether or not it is accepted.

Top module: `sbus_cmd_decoder`

## Requirements
- R1: While reset is held, and on the first edge after it, `cmd_strobe` is all zero, `init_done` is 0, `dev_addr` is 0 and `reply_pending` is 0.
- R2: While uninitialized, a long, frame-check-clean message with code 0x0, address field 0 and nonzero data bits [3:0] is accepted. It sets `init_done`, loads `dev_addr` with data bits [3:0], and pulses `cmd_strobe[0]`.
- R3: While uninitialized, an initialization message is ignored if it is a short frame, if its address field is nonzero, or if its data bits [3:0] are zero.
- R4: While uninitialized, every code other than 0x0 is ignored: no strobe and no reply.
- R5: Once initialized, code 0x0 is ignored, and `init_done` and `dev_addr` stay unchanged until reset.
- R6: A message whose frame-check flag `msg_crc_ok` is 0 is ignored.
- R7: Codes 0x3, 0x5, 0x6, 0x8, 0xE and 0xF are never accepted.
- R8: Codes 0x9, 0xA and 0xB are accepted only in long frames (`msg_long`=1).
- R9: Codes 0x1, 0x2, 0x4, 0x7, 0xC and 0xD are accepted in both long and short frames.
- R10: Code 0xB is accepted only when data bits [7:4] are zero. Its data bits [3:0] carry the register address.
- R11: Once initialized, a message whose address field differs from `dev_addr` is ignored.
- R12: An accepted message sets `cmd_strobe` bit `msg_cmd` high for exactly the one cycle after the `msg_valid` cycle. At most one strobe bit is ever high.
- R13: On every `msg_valid`, `reply_pending` takes the accept result from the following cycle on, and `reply_cmd` takes the accepted code. Both then hold until the next `msg_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | One-cycle pulse: a deframed message is present |
| msg_data | input | 8 | Message data field |
| msg_addr | input | 4 | Message address field |
| msg_cmd | input | 4 | Message command code |
| msg_long | input | 1 | 1 = long frame, 0 = short frame |
| msg_crc_ok | input | 1 | 1 = frame check passed |
| cmd_strobe | output | 16 | One-cycle strobe; bit index equals the accepted code |
| init_done | output | 1 | Device holds an assigned address |
| dev_addr | output | 4 | Assigned device address |
| reply_pending | output | 1 | A reply is due in the next transfer |
| reply_cmd | output | 4 | Code that the pending reply answers |

## Verification
The assertions check the properties that hold on every cycle. At most one strobe is high, and no unsupported code ever strobes. A strobe always follows a message and always comes with a matching pending reply. The pending flag holds between messages. Once the device is initialized, `init_done` stays high and the address stays frozen. Only the bench's scenarios can show that each specific rejection rule takes effect: frame length, address field, read-register data nibble, frame check, and initialization preconditions. They also show the value loaded as the address and that a later message overwrites an earlier reply.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;

    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef enum logic [2:0] {
        KIND_NONE,   // reserved or unimplemented
        KIND_INIT,   // address assignment, long only
        KIND_EITHER, // long or short frame
        KIND_LONG,   // long frame only
        KIND_REGRD   // long frame only, upper data bits zero
    } cmd_kind_e;

    function automatic cmd_kind_e kind_of(input logic [CODE_W-1:0] code);
        cmd_kind_e k;
        unique case (code)
            4'h0:                                 k = KIND_INIT;
            4'h1, 4'h2, 4'h4, 4'h7, 4'hC, 4'hD:   k = KIND_EITHER;
            4'h9, 4'hA:                           k = KIND_LONG;
            4'hB:                                 k = KIND_REGRD;
            default:                              k = KIND_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [NUM_CODES-1:0] unsupported_mask();
        logic [NUM_CODES-1:0] m;
        for (int i = 0; i < NUM_CODES; i++) begin
            m[i] = (kind_of(CODE_W'(i)) == KIND_NONE);
        end
        return m;
    endfunction

endpackage

// File: rtl/sbus_frame_check.sv
`timescale 1ns/1ps
module sbus_frame_check
    import sbus_pkg::*;
#(
    parameter int HI_W = 4
) (
    input  logic [CODE_W-1:0] cmd,
    input  logic              is_long,
    input  logic [HI_W-1:0]   data_hi,
    output cmd_kind_e         kind,
    output logic              shape_ok
);

    always_comb begin
        kind = kind_of(cmd);
        unique case (kind)
            KIND_INIT:   shape_ok = is_long;
            KIND_EITHER: shape_ok = 1'b1;
            KIND_LONG:   shape_ok = is_long;
            KIND_REGRD:  shape_ok = is_long && (data_hi == '0);
            default:     shape_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (kind == KIND_NONE) begin
            a_unsup_rejected_r7: assert (!shape_ok);
        end
    end

endmodule

// File: rtl/sbus_dev_state.sv
`timescale 1ns/1ps
module sbus_dev_state
    import sbus_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic              crc_ok,
    input  logic              shape_ok,
    input  cmd_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] new_addr,
    output logic              accept,
    output logic              init_done_q,
    output logic [ADDR_W-1:0] dev_addr_q
);

    typedef struct packed {
        logic              init_done;
        logic [ADDR_W-1:0] dev_addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        if (msg_valid && crc_ok && shape_ok) begin
            if (!st_q.init_done) begin
                if (kind == KIND_INIT && addr == '0 && new_addr != '0) begin
                    accept       = 1'b1;
                    st_d.init_done = 1'b1;
                    st_d.dev_addr  = new_addr;
                end
            end else if (kind != KIND_INIT && addr == st_q.dev_addr) begin
                accept = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_done_q = st_q.init_done;
    assign dev_addr_q  = st_q.dev_addr;

    p_init_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_q |=> init_done_q);

    p_addr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_q |=> $stable(dev_addr_q));

    p_addr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_q |-> (dev_addr_q != '0));

    p_crc_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (crc_ok && msg_valid));

endmodule

// File: rtl/sbus_reply_sched.sv
`timescale 1ns/1ps
module sbus_reply_sched
    import sbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    input  logic                 accept,
    input  logic [CODE_W-1:0]    cmd,
    output logic [NUM_CODES-1:0] strobe_q,
    output logic                 pending_q,
    output logic [CODE_W-1:0]    rcmd_q
);

    localparam logic [NUM_CODES-1:0] UNSUP = unsupported_mask();

    typedef struct packed {
        logic [NUM_CODES-1:0] strobe;
        logic                 pending;
        logic [CODE_W-1:0]    rcmd;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d        = rs_q;
        rs_d.strobe = '0;
        if (msg_valid) begin
            rs_d.pending = accept;
            if (accept) begin
                rs_d.rcmd        = cmd;
                rs_d.strobe[cmd] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign strobe_q  = rs_q.strobe;
    assign pending_q = rs_q.pending;
    assign rcmd_q    = rs_q.rcmd;

    p_strobe_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_q));

    p_strobe_after_msg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobe_q) |-> $past(msg_valid));

    p_no_unsup_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q & UNSUP) == '0);

    p_pending_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> ($stable(pending_q) && $stable(rcmd_q)));

    p_strobe_has_reply_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobe_q) |-> (pending_q && strobe_q[rcmd_q]));

endmodule

// File: rtl/sbus_cmd_decoder.sv
`timescale 1ns/1ps
module sbus_cmd_decoder
    import sbus_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int REG_ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    input  logic [DATA_W-1:0]    msg_data,
    input  logic [ADDR_W-1:0]    msg_addr,
    input  logic [CODE_W-1:0]    msg_cmd,
    input  logic                 msg_long,
    input  logic                 msg_crc_ok,
    output logic [NUM_CODES-1:0] cmd_strobe,
    output logic                 init_done,
    output logic [ADDR_W-1:0]    dev_addr,
    output logic                 reply_pending,
    output logic [CODE_W-1:0]    reply_cmd
);

    localparam int HI_W = DATA_W - REG_ADDR_W;

    cmd_kind_e kind;
    logic      shape_ok;
    logic      accept;

    sbus_frame_check #(.HI_W(HI_W)) u_frame (
        .cmd      (msg_cmd),
        .is_long  (msg_long),
        .data_hi  (msg_data[DATA_W-1:REG_ADDR_W]),
        .kind     (kind),
        .shape_ok (shape_ok)
    );

    sbus_dev_state #(.ADDR_W(ADDR_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .msg_valid   (msg_valid),
        .crc_ok      (msg_crc_ok),
        .shape_ok    (shape_ok),
        .kind        (kind),
        .addr        (msg_addr),
        .new_addr    (msg_data[ADDR_W-1:0]),
        .accept      (accept),
        .init_done_q (init_done),
        .dev_addr_q  (dev_addr)
    );

    sbus_reply_sched u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .accept    (accept),
        .cmd       (msg_cmd),
        .strobe_q  (cmd_strobe),
        .pending_q (reply_pending),
        .rcmd_q    (reply_cmd)
    );

    p_init_strobe_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_strobe) && !$past(init_done) |-> cmd_strobe[0]);

    p_init_strobe_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe[0] |-> !$past(init_done));

endmodule

// File: tb/sbus_cmd_decoder_test.sv
`timescale 1ns/1ps
module sbus_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_data = '0;
    logic [3:0]  msg_addr = '0;
    logic [3:0]  msg_cmd = '0;
    logic        msg_long = 1'b0;
    logic        msg_crc_ok = 1'b0;
    logic [15:0] cmd_strobe;
    logic        init_done;
    logic [3:0]  dev_addr;
    logic        reply_pending;
    logic [3:0]  reply_cmd;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sbus_cmd_decoder uut (
        .clk, .rst_n, .msg_valid, .msg_data, .msg_addr, .msg_cmd,
        .msg_long, .msg_crc_ok, .cmd_strobe, .init_done, .dev_addr,
        .reply_pending, .reply_cmd
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one message, return after the registering edge (at a negedge)
    task automatic send(input logic [7:0] d, input logic [3:0] a, input logic [3:0] c,
                        input logic lg, input logic ok);
        @(negedge clk);
        msg_data = d; msg_addr = a; msg_cmd = c; msg_long = lg; msg_crc_ok = ok;
        msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    // {data, addr, cmd, long, crc_ok, expect_accept}
    localparam int NV = 27;
    localparam logic [18:0] VEC [NV] = '{
        {8'h00, 4'h0, 4'h2, 1'b1, 1'b1, 1'b0}, // R4 read accel before init
        {8'h05, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0}, // R3 short init
        {8'h05, 4'h3, 4'h0, 1'b1, 1'b1, 1'b0}, // R3 nonzero address field
        {8'h00, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0}, // R3 zero new address
        {8'h05, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0}, // R6 bad frame check on init
        {8'h05, 4'h0, 4'h0, 1'b1, 1'b1, 1'b1}, // R2 valid init, address 5
        {8'h05, 4'h5, 4'h0, 1'b1, 1'b1, 1'b0}, // R5 second init
        {8'h00, 4'h5, 4'h1, 1'b0, 1'b1, 1'b1}, // R9 status short
        {8'h00, 4'h5, 4'h2, 1'b1, 1'b1, 1'b1}, // R9 accel long
        {8'h00, 4'h5, 4'h4, 1'b0, 1'b1, 1'b1}, // R9 id short
        {8'h00, 4'h5, 4'h7, 1'b1, 1'b1, 1'b1}, // R9 clear long
        {8'h00, 4'h5, 4'hC, 1'b0, 1'b1, 1'b1}, // R9 self-test off short
        {8'h00, 4'h5, 4'hD, 1'b1, 1'b1, 1'b1}, // R9 self-test on long
        {8'h12, 4'h5, 4'h9, 1'b0, 1'b1, 1'b0}, // R8 nvm short
        {8'h12, 4'h5, 4'h9, 1'b1, 1'b1, 1'b1}, // R8 nvm long
        {8'h34, 4'h5, 4'hA, 1'b0, 1'b1, 1'b0}, // R8 format short
        {8'h34, 4'h5, 4'hA, 1'b1, 1'b1, 1'b1}, // R8 format long
        {8'h03, 4'h5, 4'hB, 1'b1, 1'b1, 1'b1}, // R10 register read ok
        {8'h13, 4'h5, 4'hB, 1'b1, 1'b1, 1'b0}, // R10 upper nibble set
        {8'h00, 4'h5, 4'h3, 1'b1, 1'b1, 1'b0}, // R7
        {8'h00, 4'h5, 4'h5, 1'b0, 1'b1, 1'b0}, // R7
        {8'h00, 4'h5, 4'h6, 1'b1, 1'b1, 1'b0}, // R7
        {8'h00, 4'h5, 4'h8, 1'b1, 1'b1, 1'b0}, // R7
        {8'h00, 4'h5, 4'hE, 1'b0, 1'b1, 1'b0}, // R7
        {8'h00, 4'h5, 4'hF, 1'b1, 1'b1, 1'b0}, // R7
        {8'h00, 4'h6, 4'h1, 1'b1, 1'b1, 1'b0}, // R11 wrong address
        {8'h00, 4'h5, 4'h1, 1'b1, 1'b0, 1'b0}  // R6 bad frame check
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [3:0] last_rcmd;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", 32'(cmd_strobe), 0);
        chk("R1 init_done in reset", 32'(init_done), 0);
        chk("R1 pending in reset", 32'(reply_pending), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobe after reset", 32'(cmd_strobe), 0);
        chk("R1 dev_addr after reset", 32'(dev_addr), 0);

        last_rcmd = '0;
        for (int i = 0; i < NV; i++) begin
            logic [7:0] d; logic [3:0] a, c; logic lg, ok, acc;
            {d, a, c, lg, ok, acc} = VEC[i];
            send(d, a, c, lg, ok);
            if (acc) last_rcmd = c;
            chk($sformatf("R12 strobe vec %0d", i), 32'(cmd_strobe),
                acc ? (32'h1 << c) : 32'h0);
            chk($sformatf("R13 pending vec %0d", i), 32'(reply_pending), 32'(acc));
            chk($sformatf("R13 reply_cmd vec %0d", i), 32'(reply_cmd), 32'(last_rcmd));
            @(negedge clk);
            chk($sformatf("R12 strobe drop vec %0d", i), 32'(cmd_strobe), 0);
            if (i == 5) begin
                chk("R2 init_done", 32'(init_done), 1);
                chk("R2 dev_addr", 32'(dev_addr), 5);
            end
        end
        chk("R5 dev_addr kept", 32'(dev_addr), 5);
        chk("R5 init_done kept", 32'(init_done), 1);

        // R13: pending holds through idle cycles, then a rejected message clears it
        send(8'h00, 4'h5, 4'h7, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        chk("R13 pending holds idle", 32'(reply_pending), 1);
        chk("R13 reply_cmd holds idle", 32'(reply_cmd), 7);
        send(8'h00, 4'h5, 4'h3, 1'b1, 1'b1);
        chk("R13 pending cleared by rejected msg", 32'(reply_pending), 0);
        // R13: back-to-back accepted messages overwrite the reply code
        send(8'h00, 4'h5, 4'h2, 1'b0, 1'b1);
        send(8'h00, 4'h5, 4'hD, 1'b0, 1'b1);
        chk("R13 reply_cmd overwritten", 32'(reply_cmd), 32'hD);
        chk("R12 strobe second msg", 32'(cmd_strobe), 32'h2000);

        // R1: reset mid-run, then re-initialize with a different address
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 init_done cleared", 32'(init_done), 0);
        chk("R1 pending cleared", 32'(reply_pending), 0);
        rst_n = 1'b1;
        send(8'h00, 4'h5, 4'h1, 1'b1, 1'b1);
        chk("R4 old address ignored after reset", 32'(cmd_strobe), 0);
        send(8'hFA, 4'h0, 4'h0, 1'b1, 1'b1);
        chk("R2 reinit strobe", 32'(cmd_strobe), 1);
        chk("R2 reinit addr from low nibble", 32'(dev_addr), 32'hA);
        send(8'h00, 4'hA, 4'h4, 1'b1, 1'b1);
        chk("R11 new address matches", 32'(cmd_strobe), 32'h10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule